// File: doc/BRIEF.md
# Bimodal Insertion Recency Stack

This block holds the replacement order of a single set in a set-associative cache and names the line to evict. Every way has an age rank. Rank 0 is the most recently used line and rank WAYS-1 is the least recently used one. The ranks always form a permutation. A cache controller presents one request per cycle. The request says whether the lookup hit or missed, which way hit, and which insertion mode applies to a fill.

On a hit the line is promoted to rank 0. On a miss the block evicts the line at rank WAYS-1 and places the new line according to the mode:

- **Classic mode** puts the new line at the top.
- **Bottom-insert mode** leaves the new line at the bottom, so it stays the next victim unless it is hit again.
- **Bimodal mode** draws from an internal pseudo-random generator. It puts the line at the top on roughly one fill in 2^THROTTLE_LOG2 (1/32 by default) and at the bottom otherwise.

This protects part of a working set that is larger than the cache, while still letting a new working set age the old one out slowly.

Top module: `bip_recency_stack`

## Requirements
- R1: `victim_way` always equals the way whose age is WAYS-1 in the current ranks.
- R2: After reset, way i has age i, so the victim is way WAYS-1.
- R3: A miss in classic mode (`req_mode` = 0) gives the victim age 0 and adds one to the age of every other way.
- R4: A miss in bottom-insert mode (`req_mode` = 1) leaves all ages unchanged, so the filled line keeps age WAYS-1.
- R5: A hit on way h with age a gives way h age 0. Ways younger than a age by one, and ways older than a keep their age.
- R6: In bimodal mode (`req_mode` = 2) a fill goes to the top when the low THROTTLE_LOG2 bits of the 16-bit generator are all zero, and stays at the bottom otherwise. The generator details:
  - It resets to 0xACE1.
  - It steps once per miss in any mode as {r[14:0], r[15]^r[13]^r[12]^r[10]}.
  - The draw uses the value held before that step.
- R7: `fill_mru` is high exactly in the cycles where a valid miss will place its line at age 0.
- R8: With `req_valid` low, the ages and the generator stay unchanged, whatever the other request inputs carry.
- R9: `req_mode` = 3 behaves as bottom-insert mode.
- R10: The ages of all ways always form a permutation of 0..WAYS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_hit | input | 1 | 1 = hit on `req_way`, 0 = miss with fill |
| req_way | input | log2(WAYS) | Way that hit (ignored on a miss) |
| req_mode | input | 2 | Insertion mode: 0 classic, 1 bottom, 2 bimodal, 3 as bottom |
| victim_way | output | log2(WAYS) | Way at the LRU end, evicted on a miss |
| fill_mru | output | 1 | The current miss will be placed at the top |
| way_ages | output | WAYS*log2(WAYS) | Age of way i in bits [i*log2(WAYS) +: log2(WAYS)] |

## Verification
The interesting collision is a hit on the way that `victim_way` currently names: a single request sees both the LRU-end selection and a promotion. The bench provokes this by hitting the present victim, both before and during bimodal fill streams. It then judges three things:
- the hit moves that way to age 0;
- every other way ages by one;
- no fill is flagged and the generator does not step, which the later bimodal placements expose.

// File: rtl/bip_pkg.sv
package bip_pkg;

    typedef enum logic [1:0] {
        INS_TOP     = 2'd0,
        INS_BOTTOM  = 2'd1,
        INS_BIMODAL = 2'd2,
        INS_RSVD    = 2'd3
    } ins_mode_e;

    // Decide whether a fill goes to the top of the recency order.
    function automatic logic place_at_top(input logic [1:0] mode, input logic draw_zero);
        logic top;
        case (ins_mode_e'(mode))
            INS_TOP:     top = 1'b1;
            INS_BIMODAL: top = draw_zero;
            default:     top = 1'b0;
        endcase
        return top;
    endfunction

endpackage

// File: rtl/bip_lfsr.sv
module bip_lfsr #(
    parameter int          WIDTH = 16,
    parameter logic [15:0] TAPS  = 16'hB400,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [WIDTH-1:0] value
);
    logic [WIDTH-1:0] lfsr_d, lfsr_q;
    logic             feedback;

    always_comb begin
        feedback = ^(lfsr_q & TAPS[WIDTH-1:0]);
        lfsr_d   = lfsr_q;
        if (step) begin
            lfsr_d = {lfsr_q[WIDTH-2:0], feedback};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= SEED[WIDTH-1:0];
        end else begin
            lfsr_q <= lfsr_d;
        end
    end

    assign value = lfsr_q;
endmodule

// File: rtl/bip_victim_find.sv
module bip_victim_find #(
    parameter int WAYS  = 16,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][WAY_W-1:0] ages,
    output logic [WAY_W-1:0]           victim
);
    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

    always_comb begin
        victim = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (ages[i] == OLDEST) begin
                victim = WAY_W'(i);
            end
        end
    end
endmodule

// File: rtl/bip_age_lane.sv
module bip_age_lane #(
    parameter int AGE_W = 4
) (
    input  logic [AGE_W-1:0] cur_age,
    input  logic             is_target,
    input  logic [AGE_W-1:0] ref_age,
    input  logic             update,
    output logic [AGE_W-1:0] next_age
);
    always_comb begin
        next_age = cur_age;
        if (update) begin
            if (is_target) begin
                next_age = '0;
            end else if (cur_age < ref_age) begin
                next_age = cur_age + AGE_W'(1);
            end
        end
    end
endmodule

// File: rtl/bip_recency_stack.sv
module bip_recency_stack
    import bip_pkg::*;
#(
    parameter int          WAYS          = 16,
    parameter int          LFSR_W        = 16,
    parameter logic [15:0] LFSR_TAPS     = 16'hB400,
    parameter logic [15:0] LFSR_SEED     = 16'hACE1,
    parameter int          THROTTLE_LOG2 = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_hit,
    input  logic [$clog2(WAYS)-1:0]       req_way,
    input  logic [1:0]                    req_mode,
    output logic [$clog2(WAYS)-1:0]       victim_way,
    output logic                          fill_mru,
    output logic [WAYS*$clog2(WAYS)-1:0]  way_ages
);
    localparam int WAY_W = $clog2(WAYS);

    typedef logic [WAY_W-1:0] age_t;
    typedef struct packed {
        logic [WAYS-1:0][WAY_W-1:0] age;
    } rank_state_t;

    rank_state_t                 st_d, st_q;
    logic [WAYS-1:0][WAY_W-1:0]  lane_next;
    logic [WAY_W-1:0]            victim_idx;
    logic [WAY_W-1:0]            target_way;
    age_t                        ref_age;
    logic [LFSR_W-1:0]           draw;
    logic                        draw_zero;
    logic                        is_miss;
    logic                        top_fill;
    logic                        promote;

    bip_victim_find #(.WAYS(WAYS), .WAY_W(WAY_W)) u_find (
        .ages   (st_q.age),
        .victim (victim_idx)
    );

    bip_lfsr #(.WIDTH(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_rng (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (is_miss),
        .value (draw)
    );

    always_comb begin
        is_miss    = req_valid && !req_hit;
        draw_zero  = (draw[THROTTLE_LOG2-1:0] == '0);
        top_fill   = is_miss && place_at_top(req_mode, draw_zero);
        promote    = (req_valid && req_hit) || top_fill;
        target_way = req_hit ? req_way : victim_idx;
        ref_age    = st_q.age[target_way];
    end

    for (genvar g = 0; g < WAYS; g++) begin : g_lane
        bip_age_lane #(.AGE_W(WAY_W)) u_lane (
            .cur_age   (st_q.age[g]),
            .is_target (target_way == WAY_W'(g)),
            .ref_age   (ref_age),
            .update    (promote),
            .next_age  (lane_next[g])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.age = lane_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WAYS; i++) begin
                st_q.age[i] <= age_t'(i);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign victim_way = victim_idx;
    assign fill_mru   = top_fill;
    assign way_ages   = st_q.age;
endmodule

// File: rtl/bip_recency_checker.sv
module bip_recency_checker #(
    parameter int WAYS  = 16,
    parameter int WAY_W = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic                     req_hit,
    input logic [WAY_W-1:0]         req_way,
    input logic [1:0]               req_mode,
    input logic [WAY_W-1:0]         victim_way,
    input logic                     fill_mru,
    input logic [WAYS*WAY_W-1:0]    way_ages
);
    logic [WAY_W-1:0] ages [WAYS];
    logic             perm_ok;
    logic [WAY_W-1:0] vict_q;
    logic [WAY_W-1:0] hit_q;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            ages[w] = way_ages[w*WAY_W +: WAY_W];
        end
    end

    always_comb begin
        perm_ok = 1'b1;
        for (int a = 0; a < WAYS; a++) begin
            int cnt;
            cnt = 0;
            for (int w = 0; w < WAYS; w++) begin
                if (ages[w] == WAY_W'(a)) cnt++;
            end
            if (cnt != 1) perm_ok = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vict_q <= '0;
            hit_q  <= '0;
        end else begin
            vict_q <= victim_way;
            hit_q  <= req_way;
        end
    end

    AST_VICTIM_IS_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        ages[victim_way] == WAY_W'(WAYS - 1)); // R1

    AST_AGES_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
        perm_ok); // R10

    AST_TOP_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_hit && fill_mru) |=> ages[vict_q] == '0); // R3

    AST_BOTTOM_FILL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_hit && !fill_mru) |=> $stable(way_ages)); // R4

    AST_HIT_PROMOTES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_hit) |=> ages[hit_q] == '0); // R5

    AST_CLASSIC_ALWAYS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_hit && req_mode == 2'd0) |-> fill_mru); // R3

    AST_BOTTOM_NEVER_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_mode == 2'd1 || req_mode == 2'd3) |-> !fill_mru); // R9

    AST_FLAG_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        fill_mru |-> (req_valid && !req_hit)); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(way_ages)); // R8
endmodule

bind bip_recency_stack bip_recency_checker #(.WAYS(WAYS), .WAY_W(WAY_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_hit    (req_hit),
    .req_way    (req_way),
    .req_mode   (req_mode),
    .victim_way (victim_way),
    .fill_mru   (fill_mru),
    .way_ages   (way_ages)
);

// File: tb/tb_bip_recency_stack.sv
module tb_bip_recency_stack;
    localparam int WAYS = 16;
    localparam int WW   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_hit = 1'b0;
    logic [WW-1:0]     req_way = '0;
    logic [1:0]        req_mode = 2'd0;
    logic [WW-1:0]     victim_way;
    logic              fill_mru;
    logic [WAYS*WW-1:0] way_ages;

    int errors = 0;
    int checks = 0;
    int top_count = 0;
    bit done = 0;

    int          m_age [WAYS];
    logic [15:0] m_rng;

    always #4 clk = ~clk;

    bip_recency_stack dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hit(req_hit),
        .req_way(req_way), .req_mode(req_mode), .victim_way(victim_way),
        .fill_mru(fill_mru), .way_ages(way_ages)
    );

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int model_victim();
        int v = 0;
        for (int w = 0; w < WAYS; w++) if (m_age[w] == WAYS - 1) v = w;
        return v;
    endfunction

    task automatic check_ages(input string tag);
        int bad = -1;
        for (int w = 0; w < WAYS; w++) begin
            if (int'(way_ages[w*WW +: WW]) != m_age[w] && bad < 0) bad = w;
        end
        if (bad < 0) check(tag, 0, 0, "ages");
        else check(tag, int'(way_ages[bad*WW +: WW]), m_age[bad], $sformatf("age of way %0d", bad));
    endtask

    // One request: drive at negedge, check combinational outputs, clock, check ages.
    task automatic do_req(input bit v, input bit h, input int way, input int mode, input string tag);
        bit exp_top;
        int ref_a;
        int tgt;
        @(negedge clk);
        req_valid = v; req_hit = h; req_way = WW'(way); req_mode = 2'(mode);
        #1;
        exp_top = v && !h && (mode == 0 || (mode == 2 && m_rng[4:0] == 5'd0));
        check("R1", int'(victim_way), model_victim(), "victim_way");
        check(mode == 2 ? "R6" : "R7", int'(fill_mru), int'(exp_top), "fill_mru");
        if (exp_top) top_count++;
        if (v) begin
            if (h || exp_top) begin
                tgt   = h ? way : model_victim();
                ref_a = m_age[tgt];
                for (int w = 0; w < WAYS; w++) begin
                    if (w == tgt) m_age[w] = 0;
                    else if (m_age[w] < ref_a) m_age[w]++;
                end
            end
            if (!h) m_rng = {m_rng[14:0], m_rng[15] ^ m_rng[13] ^ m_rng[12] ^ m_rng[10]};
        end
        @(posedge clk);
        #1;
        check_ages(tag);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        for (int w = 0; w < WAYS; w++) m_age[w] = w;
        m_rng = 16'hACE1;
        check_ages("R2");
        check("R2", int'(victim_way), WAYS - 1, "reset victim");
        check("R7", int'(fill_mru), 0, "reset fill_mru");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_classic();
        for (int i = 0; i < 3; i++) do_req(1, 0, 0, 0, "R3");
    endtask

    task automatic t_bottom();
        for (int i = 0; i < 3; i++) do_req(1, 0, 0, 1, "R4");
    endtask

    task automatic t_hits();
        do_req(1, 1, 7, 0, "R5");
        do_req(1, 1, 7, 2, "R5");            // hit on current MRU way
        do_req(1, 1, model_victim(), 1, "R5"); // hit on the current victim
        do_req(1, 1, 3, 0, "R5");
    endtask

    task automatic t_idle();
        do_req(0, 0, 5, 0, "R8");
        do_req(0, 1, 9, 2, "R8");
        do_req(0, 0, 2, 3, "R8");
    endtask

    task automatic t_reserved();
        for (int i = 0; i < 3; i++) do_req(1, 0, 0, 3, "R9");
    endtask

    task automatic t_bimodal();
        int base = top_count;
        int perm_bad = 0;
        for (int i = 0; i < 400; i++) begin
            if (i % 9 == 4) do_req(1, 1, model_victim(), 2, "R5");
            else if (i % 13 == 6) do_req(1, 1, (i * 5) % WAYS, 2, "R5");
            else do_req(1, 0, 0, 2, "R6");
        end
        check("R6", int'(top_count > base), 1, "some bimodal fills reach top");
        for (int a = 0; a < WAYS; a++) begin
            int cnt = 0;
            for (int w = 0; w < WAYS; w++) if (int'(way_ages[w*WW +: WW]) == a) cnt++;
            if (cnt != 1) perm_bad++;
        end
        check("R10", perm_bad, 0, "ages not a permutation");
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_classic();
        t_bottom();
        t_hits();
        t_idle();
        t_reserved();
        t_bimodal();
        t_classic();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule